// File: doc/BRIEF.md
# Power Mode Controller

This block steers a device through four operating modes: active processing, idle, sleep and deep power-down. Software moves it between idle, active and sleep with 8-bit command codes. Two pins handle the rest: one wakes the device from sleep and one holds it in power-down. For each mode the block drives gating enables for the processing core clock, the peripheral clock, the PLL and the converters. It also gives an 8-bit mode code that the host can read.

When the device leaves power-down, the PLL needs time to settle. The controller therefore holds the device in sleep for a lockout window, sized from the clock frequency, and ignores the wake pin until the window has passed. Two things are reported on a sticky error output. One is a command that cannot be honoured in the active mode. The other is the power-down pin asserted outside sleep. Neither event changes the mode. A synchronous reset request takes effect only after it has been held for a minimum number of clocks. The power-on reset is asynchronous.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset, or an accepted reset request, the mode is idle, `mode_code` is 00h and `err_flag` is 0.
- R2: In idle, a command of 01h or 04h through 09h enters active mode with `mode_code` equal to that command, and 0Fh enters sleep. Any other code leaves the mode and `mode_code` unchanged.
- R3: In active mode, command 00h returns to idle. Commands 01h, 04h–09h and 0Fh are refused: mode and `mode_code` stay, and `err_flag` sets on the next edge.
- R4: In sleep, a synchronized power-down level enters power-down and wins over the wake pin. A synchronized wake level returns to idle once the lockout has expired. Commands in sleep and power-down are ignored.
- R5: Power-down holds while the synchronized power-down pin stays high. On its release the mode goes to sleep and `settle_lock` is high for SETTLE_CYC = CLK_KHZ*SETTLE_US/1000 cycles; the wake pin has no effect while it is high.
- R6: The enables {core, periph, pll, analog} are 1111 in active mode, 0111 in idle, 0010 in sleep and 0000 in power-down.
- R7: `mode_code` reads 0Fh in sleep and FFh in power-down.
- R8: `wake_pin`, `pdn_pin` and `rst_req` pass through two flops before use. A pin change set up before clock edge n first changes the mode at edge n+2.
- R9: The power-down pin seen high in idle or active mode sets `err_flag` without a mode change. `err_flag` stays set until reset.
- R10: A reset request is accepted only after its synchronized level has been high for RST_MIN consecutive cycles. A shorter pulse changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Runtime reset request, active high, length-qualified |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| wake_pin | input | 1 | Wake request from sleep, asynchronous |
| pdn_pin | input | 1 | Power-down hold, asynchronous |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| pll_en | output | 1 | PLL enable |
| analog_en | output | 1 | Converter enable |
| mode_code | output | 8 | Host-readable mode code |
| err_flag | output | 1 | Sticky illegal-event flag |
| settle_lock | output | 1 | PLL settling lockout active |

## Verification
A wrong mode register is visible at once on `mode_code` and on the four enables, in the cycle after the faulty edge. The bench's reference model compares both every clock. A wrong lockout count shows on `settle_lock` and, some cycles later, as a wake accepted too early or too late. A synchronizer or reset-filter depth error moves every pin-driven transition by whole cycles, so the per-cycle comparison catches it at the first pin event.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_RUN   = 2'd1,
    M_SLEEP = 2'd2,
    M_PDOWN = 2'd3
  } pmode_t;

  typedef struct packed {
    logic core;
    logic periph;
    logic pll;
    logic analog;
  } gates_t;

  localparam logic [7:0] CMD_HALT  = 8'h00;
  localparam logic [7:0] CMD_SLEEP = 8'h0F;
  localparam logic [7:0] CODE_PDN  = 8'hFF;

  // Commands that start an algorithm (decode or voice rate).
  function automatic logic is_start_cmd(input logic [7:0] c);
    return (c == 8'h01) || ((c >= 8'h04) && (c <= 8'h09));
  endfunction

  function automatic gates_t gates_of(input pmode_t m);
    case (m)
      M_RUN:   return '{core: 1'b1, periph: 1'b1, pll: 1'b1, analog: 1'b1};
      M_IDLE:  return '{core: 1'b0, periph: 1'b1, pll: 1'b1, analog: 1'b1};
      M_SLEEP: return '{core: 1'b0, periph: 1'b0, pll: 1'b1, analog: 1'b0};
      default: return '{core: 1'b0, periph: 1'b0, pll: 1'b0, analog: 1'b0};
    endcase
  endfunction

  function automatic logic [7:0] code_of(input pmode_t m, input logic [7:0] run_code);
    case (m)
      M_IDLE:  return 8'h00;
      M_RUN:   return run_code;
      M_SLEEP: return CMD_SLEEP;
      default: return CODE_PDN;
    endcase
  endfunction

endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_async[b];
        s2 <= s1;
      end
    end
    assign q_sync[b] = s2;
  end
endmodule

// File: rtl/pwr_reset_filter.sv
module pwr_reset_filter #(
  parameter int RST_MIN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic req_s,
  output logic soft_rst
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_MIN);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          run_len <= '0;
    else if (!req_s)     run_len <= '0;
    else if (run_len != LIM) run_len <= run_len + 1'b1;
  end

  assign soft_rst = (run_len == LIM);

  // R10: no acceptance unless the request was high on the previous cycle
  assert_reset_qualified_R10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(soft_rst) |-> $past(req_s));
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int SETTLE_CYC = 7500
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic load,
  output logic busy
);
  localparam int LW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [LW-1:0] LOADV = LW'(SETTLE_CYC);

  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            left <= '0;
    else if (clr)          left <= '0;
    else if (load)         left <= LOADV;
    else if (left != '0)   left <= left - 1'b1;
  end

  assign busy = (left != '0);

  // R5: a load arms the full window
  assert_window_armed_R5: assert property (@(posedge clk) disable iff (!por_n)
    (load && !clr) |=> (left == LOADV));
  // R5: the window only shrinks unless reloaded
  assert_window_drains_R5: assert property (@(posedge clk) disable iff (!por_n)
    (busy && !load && !clr) |=> (left == $past(left) - 1'b1));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CLK_KHZ   = 50000,
  parameter int SETTLE_US = 150,
  parameter int RST_MIN   = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_req,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       wake_pin,
  input  logic       pdn_pin,
  output logic       core_clk_en,
  output logic       periph_clk_en,
  output logic       pll_en,
  output logic       analog_en,
  output logic [7:0] mode_code,
  output logic       err_flag,
  output logic       settle_lock
);
  localparam int SETTLE_CYC = (CLK_KHZ * SETTLE_US) / 1000;

  // Synchronized pins: [2]=reset request, [1]=power-down, [0]=wake
  logic [2:0] pins_s;
  logic       wake_s, pdn_s, rreq_s;

  pwr_pin_sync #(.W(3)) u_sync (
    .clk(clk), .por_n(por_n),
    .d_async({rst_req, pdn_pin, wake_pin}),
    .q_sync(pins_s)
  );
  assign wake_s = pins_s[0];
  assign pdn_s  = pins_s[1];
  assign rreq_s = pins_s[2];

  logic soft_rst;
  pwr_reset_filter #(.RST_MIN(RST_MIN)) u_rflt (
    .clk(clk), .por_n(por_n), .req_s(rreq_s), .soft_rst(soft_rst)
  );

  pmode_t     mode_q, mode_d;
  logic [7:0] run_q, run_d;
  logic       err_q;

  // Named internal events
  logic ev_start, ev_halt, ev_sleep, ev_bad_cmd, ev_bad_pdn;
  logic ev_enter_pd, ev_leave_pd, ev_wake;

  assign ev_start    = (mode_q == M_IDLE) && cmd_valid && is_start_cmd(cmd_code);
  assign ev_sleep    = (mode_q == M_IDLE) && cmd_valid && (cmd_code == CMD_SLEEP);
  assign ev_halt     = (mode_q == M_RUN)  && cmd_valid && (cmd_code == CMD_HALT);
  assign ev_bad_cmd  = (mode_q == M_RUN)  && cmd_valid &&
                       (is_start_cmd(cmd_code) || (cmd_code == CMD_SLEEP));
  assign ev_bad_pdn  = pdn_s && ((mode_q == M_IDLE) || (mode_q == M_RUN));
  assign ev_enter_pd = (mode_q == M_SLEEP) && pdn_s;
  assign ev_wake     = (mode_q == M_SLEEP) && !pdn_s && wake_s && !settle_lock;
  assign ev_leave_pd = (mode_q == M_PDOWN) && !pdn_s;

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    if (ev_start) begin
      mode_d = M_RUN;
      run_d  = cmd_code;
    end else if (ev_sleep)    mode_d = M_SLEEP;
    else if (ev_halt)         mode_d = M_IDLE;
    else if (ev_enter_pd)     mode_d = M_PDOWN;
    else if (ev_wake)         mode_d = M_IDLE;
    else if (ev_leave_pd)     mode_d = M_SLEEP;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= M_IDLE;
      run_q  <= 8'h00;
      err_q  <= 1'b0;
    end else if (soft_rst) begin
      mode_q <= M_IDLE;
      run_q  <= 8'h00;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      err_q  <= err_q | ev_bad_cmd | ev_bad_pdn;
    end
  end

  pwr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .por_n(por_n), .clr(soft_rst),
    .load(ev_leave_pd), .busy(settle_lock)
  );

  gates_t g;
  assign g             = gates_of(mode_q);
  assign core_clk_en   = g.core;
  assign periph_clk_en = g.periph;
  assign pll_en        = g.pll;
  assign analog_en     = g.analog;
  assign mode_code     = code_of(mode_q, run_q);
  assign err_flag      = err_q;

  // R1: accepted reset request lands in idle without error
  assert_soft_reset_idle_R1: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (mode_code == 8'h00) && !err_flag);
  // R3: refused command keeps the mode and raises the flag
  assert_refuse_in_run_R3: assert property (@(posedge clk) disable iff (!por_n)
    (ev_bad_cmd && !soft_rst) |=> $stable(mode_code) && err_flag);
  // R5: wake has no effect during lockout
  assert_wake_blocked_R5: assert property (@(posedge clk) disable iff (!por_n)
    ((mode_q == M_SLEEP) && settle_lock && !pdn_s && !soft_rst) |=> (mode_code == CMD_SLEEP));
  // R5: leaving power-down goes to sleep with lockout raised
  assert_pd_exit_R5: assert property (@(posedge clk) disable iff (!por_n)
    (ev_leave_pd && !soft_rst) |=> (mode_code == CMD_SLEEP) && settle_lock);
  // R6: the core never runs without peripherals and PLL
  assert_gate_order_R6: assert property (@(posedge clk) disable iff (!por_n)
    core_clk_en |-> (periph_clk_en && pll_en && analog_en));
  // R9: flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    (err_flag && !soft_rst) |=> err_flag);
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_KHZ = 1000, SETTLE_US = 20, RST_MIN = 16;
  localparam int SETTLE = CLK_KHZ * SETTLE_US / 1000;

  logic clk = 0, por_n = 0, rst_req = 0, cmd_valid = 0, wake_pin = 0, pdn_pin = 0;
  logic [7:0] cmd_code = 0;
  logic core_clk_en, periph_clk_en, pll_en, analog_en, err_flag, settle_lock;
  logic [7:0] mode_code;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(SETTLE_US), .RST_MIN(RST_MIN)) i_pwr_mode_ctrl (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wake_pin(wake_pin), .pdn_pin(pdn_pin), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .pll_en(pll_en), .analog_en(analog_en),
    .mode_code(mode_code), .err_flag(err_flag), .settle_lock(settle_lock));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: 0 idle, 1 active, 2 sleep, 3 power-down
  int m_mode, m_lock, m_rlen;
  bit [7:0] m_run;
  bit m_err;
  bit [1:0] wq, pq, rq;

  function automatic bit starts(input bit [7:0] c);
    return c == 8'h01 || (c >= 8'h04 && c <= 8'h09);
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      m_mode = 0; m_run = 0; m_err = 0; m_lock = 0; m_rlen = 0; wq = 0; pq = 0; rq = 0;
    end else begin
      bit w, p, load;
      w = wq[1]; p = pq[1]; load = 0;
      if (m_rlen == RST_MIN) begin
        m_mode = 0; m_run = 0; m_err = 0; m_lock = 0;
      end else begin
        if (p && m_mode <= 1) m_err = 1;
        case (m_mode)
          0: if (cmd_valid && starts(cmd_code)) begin m_mode = 1; m_run = cmd_code; end
             else if (cmd_valid && cmd_code == 8'h0F) m_mode = 2;
          1: if (cmd_valid && cmd_code == 8'h00) m_mode = 0;
             else if (cmd_valid && (starts(cmd_code) || cmd_code == 8'h0F)) m_err = 1;
          2: if (p) m_mode = 3; else if (w && m_lock == 0) m_mode = 0;
          default: if (!p) begin m_mode = 2; load = 1; end
        endcase
        if (load) m_lock = SETTLE; else if (m_lock > 0) m_lock--;
      end
      m_rlen = rq[1] ? ((m_rlen < RST_MIN) ? m_rlen + 1 : RST_MIN) : 0;
      wq = {wq[0], wake_pin}; pq = {pq[0], pdn_pin}; rq = {rq[0], rst_req};
    end
    #5;
    begin
      bit [7:0] ec; bit [3:0] eg, ag;
      case (m_mode)
        0: begin ec = 8'h00; eg = 4'b0111; end
        1: begin ec = m_run; eg = 4'b1111; end
        2: begin ec = 8'h0F; eg = 4'b0010; end
        default: begin ec = 8'hFF; eg = 4'b0000; end
      endcase
      ag = {core_clk_en, periph_clk_en, pll_en, analog_en};
      check(mode_code == ec, "R7 model mode_code", mode_code, ec);
      check(ag == eg, "R6 model enables", ag, eg);
      check(err_flag == m_err, "R9 model err_flag", err_flag, m_err);
      check(settle_lock == (m_lock != 0), "R5 model settle_lock", settle_lock, m_lock != 0);
    end
  end

  task automatic send(input bit [7:0] c);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(negedge clk); cmd_valid = 0; cmd_code = 8'hAA;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitn(3); por_n = 1; waitn(1);
    check(mode_code == 8'h00, "R1 reset code", mode_code, 0);
    check(err_flag == 0, "R1 reset err", err_flag, 0);
    check({core_clk_en, periph_clk_en, pll_en, analog_en} == 4'b0111, "R6 idle gates",
          {core_clk_en, periph_clk_en, pll_en, analog_en}, 4'b0111);
    send(8'h10);
    check(mode_code == 8'h00, "R2 unknown code in idle", mode_code, 0);
    send(8'h05);
    check(mode_code == 8'h05, "R2 start 05h", mode_code, 5);
    check(core_clk_en == 1, "R6 run core on", core_clk_en, 1);
    send(8'h01);
    check(mode_code == 8'h05 && err_flag, "R3 refused 01h in run", {err_flag, mode_code}, 9'h105);
    // short reset request ignored
    @(negedge clk); rst_req = 1; waitn(5); rst_req = 0; waitn(4);
    check(err_flag == 1 && mode_code == 8'h05, "R10 short request ignored", {err_flag, mode_code}, 9'h105);
    @(negedge clk); rst_req = 1; waitn(RST_MIN + 3); rst_req = 0; waitn(3);
    check(err_flag == 0 && mode_code == 8'h00, "R1 R10 qualified reset", {err_flag, mode_code}, 0);
    send(8'h09); send(8'h00);
    check(mode_code == 8'h00, "R3 halt returns idle", mode_code, 0);
    send(8'h0F);
    check(mode_code == 8'h0F && pll_en && !periph_clk_en, "R7 sleep code", mode_code, 8'h0F);
    send(8'h01);
    check(mode_code == 8'h0F, "R4 command ignored in sleep", mode_code, 8'h0F);
    @(negedge clk); pdn_pin = 1; wake_pin = 1; waitn(2);
    check(mode_code == 8'h0F, "R8 two-flop delay", mode_code, 8'h0F);
    waitn(1);
    check(mode_code == 8'hFF, "R4 R8 enter power-down over wake", mode_code, 8'hFF);
    waitn(5);
    check(mode_code == 8'hFF && !pll_en, "R5 hold while pin high", mode_code, 8'hFF);
    pdn_pin = 0; waitn(3);
    check(mode_code == 8'h0F && settle_lock, "R5 exit to sleep locked", {settle_lock, mode_code}, 9'h10F);
    waitn(SETTLE - 2);
    check(mode_code == 8'h0F, "R5 wake ignored in lockout", mode_code, 8'h0F);
    waitn(4);
    check(mode_code == 8'h00 && !settle_lock, "R4 wake after lockout", mode_code, 0);
    wake_pin = 0;
    @(negedge clk); pdn_pin = 1; waitn(3); pdn_pin = 0; waitn(4);
    check(err_flag == 1 && mode_code == 8'h00, "R9 pdn in idle flagged", {err_flag, mode_code}, 9'h100);
    waitn(5);
    check(err_flag == 1, "R9 flag sticky", err_flag, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule